// File: doc/BRIEF.md
# Reciprocal Seed Special-Case Front End

This block sits at the start of a single-precision reciprocal-approximation datapath. Each accepted operation presents a numerator and a denominator in IEEE-754 binary32 encoding. The block classifies both operands in parallel as quiet NaN, signalling NaN, infinity, zero, denormal or normal. From those classes it settles four outputs: the 32-bit result word, the exception flags, and an 8-bit scale predicate. The later table-based refinement and the software fix-up sequence use these outputs.

For operand pairs that need no special handling, the block returns a coarse seed. The seed's exponent field is fixed one below the bias, and a small computed table indexed by the leading denominator fraction bits supplies the upper fraction bits. A denormal on that path sets the scale predicate so that software rescales before it iterates. Every special case returns a fixed word and a zero predicate. The outputs are registered with one cycle of latency and hold their value between accepted operations.

Top module: `fpr_recip_front`

## Requirements
- R1: While reset is active and after it is released, before the first accepted operation, out_valid, result_o, pred_o, flag_invalid and flag_divzero are all zero.
- R2: An operation accepted with in_valid high at a clock edge appears on the outputs at that same edge, and out_valid is high for that cycle. When in_valid is low, result_o, pred_o and both flags keep their previous values and out_valid is low.
- R3: If either operand is a quiet NaN (exponent 0xFF, non-zero fraction, fraction bit 22 set) and neither operand is signalling, result_o is 0xFFFFFFFF, pred_o is 0x00 and neither flag is raised.
- R4: If either operand is a signalling NaN (exponent 0xFF, non-zero fraction, fraction bit 22 clear), result_o is 0xFFFFFFFF, pred_o is 0x00 and flag_invalid is raised. This holds even when the other operand is a quiet NaN.
- R5: A finite non-zero numerator (normal or denormal) with a denominator of +0 or -0 gives result_o 0x3F800000, pred_o 0x00 and flag_divzero, without flag_invalid.
- R6: An infinite numerator with a zero denominator gives result_o 0x3F800000, pred_o 0x00 and no flag.
- R7: Zero divided by zero, and infinity divided by infinity (any signs, no NaN present), give result_o 0xFFFFFFFF, pred_o 0x00 and flag_invalid.
- R8: Any other pair without a NaN in which at least one operand is zero or infinite (0/x, inf/x, x/inf, 0/inf) gives result_o 0x3F800000, pred_o 0x00 and no flag.
- R9: When both operands are finite and non-zero, result_o is {den sign, 0x7E, seed, 16 zero bits}. The 7-bit seed in bits 22:16 is min(127, floor(2048/(8+k)) - 128), where k is denominator bits 22:20. No flag is raised.
- R10: On the R9 path, pred_o is 0x80 when the numerator or the denominator is denormal (exponent 0, non-zero fraction) and 0x00 otherwise. On every special path it is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Accept num_i and den_i this cycle |
| num_i | input | 32 | Numerator, binary32 |
| den_i | input | 32 | Denominator, binary32 |
| out_valid | output | 1 | Outputs carry a newly accepted operation |
| result_o | output | 32 | Seed or special-case result word |
| pred_o | output | 8 | Scale predicate, 0x80 requests rescaling |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_divzero | output | 1 | Divide-by-zero flag |

## Verification
Uniform random 32-bit words almost never form NaNs, infinities, zeros or denormals, so the rare pairings are the hard part. The most important are a quiet NaN against a signalling NaN, a denormal meeting a zero, and an infinity over a zero. The stimulus therefore first draws an operand class for each side from a six-way pick, then fills in random sign and fraction bits within that class. Every pairing of classes, in both orders, comes up many times. Directed vectors pin the exact boundary words and the two ends of the seed table.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int MAG_W = EXP_W + MAN_W;
  localparam int FP_W  = MAG_W + 1;

  typedef struct packed {
    logic is_qnan;
    logic is_snan;
    logic is_inf;
    logic is_zero;
    logic is_denorm;
  } fp_class_t;

  // Fraction of 2/(1+f) for f = i / 2**idx_w, scaled to seed_w bits, saturated.
  function automatic int seed_value(int i, int idx_w, int seed_w);
    int num;
    int v;
    num = (2 ** (seed_w + 1)) * (2 ** idx_w);
    v   = num / ((2 ** idx_w) + i) - (2 ** seed_w);
    if (v > (2 ** seed_w) - 1) v = (2 ** seed_w) - 1;
    return v;
  endfunction

endpackage

// File: rtl/fpr_classify.sv
module fpr_classify
  import fpr_pkg::*;
(
  input  logic [MAG_W-1:0] mag_i,
  output fp_class_t        cls_o
);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max;
  logic             exp_min;
  logic             man_nz;

  always_comb begin
    exp_f   = mag_i[MAG_W-1:MAN_W];
    man_f   = mag_i[MAN_W-1:0];
    exp_max = &exp_f;
    exp_min = ~|exp_f;
    man_nz  = |man_f;
    cls_o.is_qnan   = exp_max & man_nz & man_f[MAN_W-1];
    cls_o.is_snan   = exp_max & man_nz & ~man_f[MAN_W-1];
    cls_o.is_inf    = exp_max & ~man_nz;
    cls_o.is_zero   = exp_min & ~man_nz;
    cls_o.is_denorm = exp_min & man_nz;
  end

endmodule

// File: rtl/fpr_seed_lut.sv
module fpr_seed_lut
  import fpr_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int SEED_W = 7
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [SEED_W-1:0] seed_o
);

  localparam int ENTRIES = 2 ** IDX_W;

  logic [SEED_W-1:0] table_w [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign table_w[g] = SEED_W'(seed_value(g, IDX_W, SEED_W));
  end

  assign seed_o = table_w[idx_i];

endmodule

// File: rtl/fpr_decide.sv
module fpr_decide
  import fpr_pkg::*;
#(
  parameter int          SEED_W     = 7,
  parameter int          PRED_W     = 8,
  parameter logic [7:0]  PRED_SCALE = 8'h80
) (
  input  fp_class_t         cls_n_i,
  input  fp_class_t         cls_d_i,
  input  logic              den_sign_i,
  input  logic [SEED_W-1:0] seed_i,
  output logic [FP_W-1:0]   result_o,
  output logic [PRED_W-1:0] pred_o,
  output logic              inv_o,
  output logic              dbz_o
);

  localparam logic [FP_W-1:0]  ALL_ONES  = '1;
  localparam logic [FP_W-1:0]  ONE_WORD  = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};
  localparam logic [EXP_W-1:0] RECIP_EXP = EXP_W'((2 ** (EXP_W-1)) - 2);
  localparam int               PAD_W     = MAN_W - SEED_W;

  logic any_nan;
  logic any_snan;
  logic indeterminate;
  logic n_special;

  always_comb begin
    any_snan      = cls_n_i.is_snan | cls_d_i.is_snan;
    any_nan       = any_snan | cls_n_i.is_qnan | cls_d_i.is_qnan;
    indeterminate = (cls_n_i.is_zero & cls_d_i.is_zero) |
                    (cls_n_i.is_inf  & cls_d_i.is_inf);
    n_special     = cls_n_i.is_zero | cls_n_i.is_inf | cls_d_i.is_inf;

    result_o = ONE_WORD;
    pred_o   = '0;
    inv_o    = 1'b0;
    dbz_o    = 1'b0;

    if (any_nan) begin
      result_o = ALL_ONES;
      inv_o    = any_snan;
    end else if (indeterminate) begin
      result_o = ALL_ONES;
      inv_o    = 1'b1;
    end else if (cls_d_i.is_zero) begin
      dbz_o    = ~cls_n_i.is_inf;
    end else if (n_special) begin
      result_o = ONE_WORD;
    end else begin
      result_o = {den_sign_i, RECIP_EXP, seed_i, {PAD_W{1'b0}}};
      if (cls_n_i.is_denorm | cls_d_i.is_denorm) pred_o = PRED_W'(PRED_SCALE);
    end
  end

endmodule

// File: rtl/fpr_recip_front.sv
module fpr_recip_front
  import fpr_pkg::*;
#(
  parameter int         SEED_IDX_W = 3,
  parameter int         SEED_W     = 7,
  parameter int         PRED_W     = 8,
  parameter logic [7:0] PRED_SCALE = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       num_i,
  input  logic [31:0]       den_i,
  output logic              out_valid,
  output logic [31:0]       result_o,
  output logic [PRED_W-1:0] pred_o,
  output logic              flag_invalid,
  output logic              flag_divzero
);

  // reset synchronizer: asserted asynchronously, released on clock
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  fp_class_t cls_n;
  fp_class_t cls_d;
  logic [SEED_W-1:0] seed;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    if (g == 0) begin : g_num
      fpr_classify u_cls (.mag_i(num_i[MAG_W-1:0]), .cls_o(cls_n));
    end else begin : g_den
      fpr_classify u_cls (.mag_i(den_i[MAG_W-1:0]), .cls_o(cls_d));
    end
  end

  fpr_seed_lut #(.IDX_W(SEED_IDX_W), .SEED_W(SEED_W)) u_lut (
    .idx_i  (den_i[MAN_W-1 -: SEED_IDX_W]),
    .seed_o (seed)
  );

  logic [FP_W-1:0]   dec_result;
  logic [PRED_W-1:0] dec_pred;
  logic              dec_inv;
  logic              dec_dbz;

  fpr_decide #(.SEED_W(SEED_W), .PRED_W(PRED_W), .PRED_SCALE(PRED_SCALE)) u_dec (
    .cls_n_i    (cls_n),
    .cls_d_i    (cls_d),
    .den_sign_i (den_i[FP_W-1]),
    .seed_i     (seed),
    .result_o   (dec_result),
    .pred_o     (dec_pred),
    .inv_o      (dec_inv),
    .dbz_o      (dec_dbz)
  );

  // next-state
  logic              nxt_valid;
  logic [31:0]       nxt_result;
  logic [PRED_W-1:0] nxt_pred;
  logic              nxt_inv;
  logic              nxt_dbz;
  logic              load_en;

  always_comb begin
    load_en    = in_valid;
    nxt_valid  = in_valid;
    nxt_result = result_o;
    nxt_pred   = pred_o;
    nxt_inv    = flag_invalid;
    nxt_dbz    = flag_divzero;
    if (load_en) begin
      nxt_result = dec_result;
      nxt_pred   = dec_pred;
      nxt_inv    = dec_inv;
      nxt_dbz    = dec_dbz;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid    <= 1'b0;
      result_o     <= '0;
      pred_o       <= '0;
      flag_invalid <= 1'b0;
      flag_divzero <= 1'b0;
    end else begin
      out_valid    <= nxt_valid;
      result_o     <= nxt_result;
      pred_o       <= nxt_pred;
      flag_invalid <= nxt_inv;
      flag_divzero <= nxt_dbz;
    end
  end

  // assertions
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> (!out_valid && $stable(result_o) && $stable(pred_o) && $stable(flag_invalid))); // R2
  AST_NAN_ONES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && (&num_i[30:23]) && (|num_i[22:0])) |=> (result_o == 32'hFFFF_FFFF && pred_o == '0)); // R3
  AST_SNAN_INVALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && (&den_i[30:23]) && (|den_i[22:0]) && !den_i[22]) |=> flag_invalid); // R4
  AST_DBZ_ONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && flag_divzero) |-> (result_o == 32'h3F80_0000 && !flag_invalid)); // R5
  AST_PRED_SEED_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && pred_o != '0) |-> (result_o[30:23] == 8'h7E && !flag_invalid && !flag_divzero)); // R10

endmodule

// File: tb/sim_fpr_recip_front.sv
module sim_fpr_recip_front;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] num_i;
  logic [31:0] den_i;
  logic        out_valid;
  logic [31:0] result_o;
  logic [7:0]  pred_o;
  logic        flag_invalid;
  logic        flag_divzero;

  int n_checks;
  int n_fail;

  fpr_recip_front u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .num_i(num_i), .den_i(den_i),
    .out_valid(out_valid), .result_o(result_o), .pred_o(pred_o),
    .flag_invalid(flag_invalid), .flag_divzero(flag_divzero)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // class codes: 0 qnan, 1 snan, 2 inf, 3 zero, 4 denorm, 5 normal
  function automatic logic [31:0] make_op(int c, logic [31:0] r);
    logic [7:0] e;
    case (c)
      0: return {r[31], 8'hFF, 1'b1, r[21:0]};
      1: return {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
      2: return {r[31], 8'hFF, 23'd0};
      3: return {r[31], 31'd0};
      4: return {r[31], 8'h00, r[22:1], 1'b1};
      default: begin
        e = r[30:23];
        if (e == 8'h00) e = 8'h01;
        if (e == 8'hFF) e = 8'hFE;
        return {r[31], e, r[22:0]};
      end
    endcase
  endfunction

  function automatic logic [41:0] ref_model(logic [31:0] n, logic [31:0] d);
    logic nq, ns, ni, nz, nd, dq, ds, di, dz, dd;
    int k, s;
    nq = (n[30:23] == 8'hFF) && (n[22:0] != 0) && n[22];
    ns = (n[30:23] == 8'hFF) && (n[22:0] != 0) && !n[22];
    ni = (n[30:23] == 8'hFF) && (n[22:0] == 0);
    nz = (n[30:0] == 0);
    nd = (n[30:23] == 0) && (n[22:0] != 0);
    dq = (d[30:23] == 8'hFF) && (d[22:0] != 0) && d[22];
    ds = (d[30:23] == 8'hFF) && (d[22:0] != 0) && !d[22];
    di = (d[30:23] == 8'hFF) && (d[22:0] == 0);
    dz = (d[30:0] == 0);
    dd = (d[30:23] == 0) && (d[22:0] != 0);
    if (nq || ns || dq || ds) return {32'hFFFF_FFFF, 8'h00, (ns || ds), 1'b0};
    if ((nz && dz) || (ni && di)) return {32'hFFFF_FFFF, 8'h00, 2'b10};
    if (dz) return {32'h3F80_0000, 8'h00, 1'b0, !ni};
    if (nz || ni || di) return {32'h3F80_0000, 8'h00, 2'b00};
    k = int'(d[22:20]);
    s = 2048 / (8 + k) - 128;
    if (s > 127) s = 127;
    return {d[31], 8'h7E, 7'(s), 16'h0000, ((nd || dd) ? 8'h80 : 8'h00), 2'b00};
  endfunction

  task automatic check_out(string tag, logic ev, logic [41:0] exp_v);
    logic [41:0] act;
    act = {result_o, pred_o, flag_invalid, flag_divzero};
    n_checks++;
    if (out_valid !== ev || act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: valid=%0b res=%h pred=%h inv=%0b dbz=%0b expected valid=%0b res=%h pred=%h inv=%0b dbz=%0b",
               tag, out_valid, act[41:10], act[9:2], act[1], act[0],
               ev, exp_v[41:10], exp_v[9:2], exp_v[1], exp_v[0]);
    end
  endtask

  task automatic apply(string tag, logic [31:0] n, logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    num_i    = n;
    den_i    = d;
    @(posedge clk);
    #2;
    check_out(tag, 1'b1, ref_model(n, d));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [41:0] last;
    int dummy;
    n_checks = 0;
    n_fail   = 0;
    dummy    = $urandom(32'd1234);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    num_i    = 32'h7FC0_0000;
    den_i    = 32'h0;
    repeat (3) @(posedge clk);
    #2;
    check_out("R1 in reset", 1'b0, 42'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check_out("R1 after release", 1'b0, 42'd0);

    apply("R3 qnan num",        32'h7FC0_0000, 32'h3F80_0000);
    apply("R3 qnan den",        32'h3F80_0000, 32'h7FC0_0000);
    apply("R3 qnan both",       32'hFFC0_0001, 32'h7FC0_0000);
    apply("R4 snan num",        32'h7F80_0001, 32'h3F80_0000);
    apply("R4 snan den",        32'h3F80_0000, 32'h7F80_0001);
    apply("R4 qnan with snan",  32'h7FC0_0000, 32'hFFA0_0000);
    apply("R5 neg over -0",     32'h885D_C960, 32'h8000_0000);
    apply("R5 denorm over +0",  32'h0000_0001, 32'h0000_0000);
    apply("R6 inf over zero",   32'h7F80_0000, 32'h0000_0000);
    apply("R7 zero over zero",  32'h8000_0000, 32'h0000_0000);
    apply("R7 inf over inf",    32'hFF80_0000, 32'h7F80_0000);
    apply("R8 zero over x",     32'h0000_0000, 32'h4040_0000);
    apply("R8 x over inf",      32'h4040_0000, 32'hFF80_0000);
    apply("R8 zero over inf",   32'h0000_0000, 32'h7F80_0000);
    apply("R8 denorm over inf", 32'h0000_0010, 32'h7F80_0000);
    apply("R9 seed k0",         32'h3F80_0000, 32'h4000_0000);
    apply("R9 seed k7 neg",     32'h3F80_0000, 32'hC0F0_0000);
    apply("R9 seed k3",         32'h4120_0000, 32'h3FB0_0000);
    apply("R10 denorm num",     32'h0000_0001, 32'h3460_01D6);
    apply("R10 denorm den",     32'h3F80_0000, 32'h8000_0007);
    apply("R10 both denorm",    32'h0001_0000, 32'h0040_0000);

    // R2: idle cycles keep the previous outputs
    last = ref_model(32'h0000_0001, 32'h3460_01D6);
    apply("R2 load", 32'h0000_0001, 32'h3460_01D6);
    @(negedge clk);
    in_valid = 1'b0;
    num_i    = 32'h7F80_0001;
    den_i    = 32'h0000_0000;
    @(posedge clk);
    #2;
    check_out("R2 hold 1", 1'b0, last);
    @(posedge clk);
    #2;
    check_out("R2 hold 2", 1'b0, last);

    for (int i = 0; i < 600; i++) begin
      int cn, cd;
      cn = int'($urandom_range(5, 0));
      cd = int'($urandom_range(5, 0));
      apply("random class pair", make_op(cn, $urandom()), make_op(cd, $urandom()));
      if ($urandom_range(3, 0) == 0) begin
        last = {result_o, pred_o, flag_invalid, flag_divzero};
        @(negedge clk);
        in_valid = 1'b0;
        num_i    = $urandom();
        den_i    = $urandom();
        @(posedge clk);
        #2;
        check_out("R2 random idle", 1'b0, last);
      end
    end

    @(negedge clk);
    in_valid = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule